// File: doc/BRIEF.md
# Strobed Register Write Port

This block is the receiving end of a three-wire programming link: a host raises a select strobe, toggles an interface clock, and presents bits or bytes on a data input. Every complete transfer is a 16-bit frame holding an 8-bit register address followed by 8 bits of write data. The block decodes these frames and writes them into a local file of 256 eight-bit registers. The rest of the device reads that file through an internal read port and may follow each write through a one-cycle write notification.

A static mode strap chooses how frames arrive. With the strap at 1, all 16 bits come one at a time on data bit 0. With the strap at 0, the address and the data each come as a whole byte on the 8-bit data bus, so a frame takes two clock edges. All three host signals are asynchronous to the system clock. Each passes through a two-stage synchronizer, and the host clock is edge-detected in the system domain. The system clock must therefore run at least four times faster than the host clock.

Top module: `strbport`

## Requirements
- R1: After active-low reset every one of the 256 registers reads 0 and `wr_pulse` is low.
- R2: With `mode_serial` = 1, a frame is 16 bits taken from `host_data[0]`, most significant bit first. The first 8 bits are the register address and the last 8 bits are the write data.
- R3: With `mode_serial` = 0, the first strobed rising host clock edge captures `host_data[7:0]` as the address. The second such edge captures `host_data[7:0]` as the write data.
- R4: Data is sampled only on rising host clock edges. Bench stimulus that changes the data while the host clock is high or falling must not alter the captured frame.
- R5: While `host_strobe` is low, host clock edges are ignored: they cause no write, and they leave no bits that count toward the next frame.
- R6: If the strobe falls before a frame is complete, the partial frame is discarded and no register changes.
- R7: Each complete frame produces exactly one `wr_pulse`, one system cycle wide, with `wr_addr`/`wr_data` holding the frame's address and data. On the next cycle the addressed register holds that data.
- R8: Once a frame completes, further rising edges under the same strobe begin a new frame, so several frames can be sent back to back in one strobe window.
- R9: A write changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_strobe | input | 1 | Port select from host, active high, asynchronous |
| host_clk | input | 1 | Host interface clock, asynchronous; rising edges sample data |
| host_data | input | 8 | Host data; bit 0 only in serial mode, full byte in parallel mode |
| mode_serial | input | 1 | Static strap: 1 = serial frames, 0 = byte-wide frames |
| rd_addr | input | 8 | Internal read address into the register file |
| rd_data | output | 8 | Register contents at `rd_addr` (combinational) |
| wr_pulse | output | 1 | One-cycle notice that a frame has committed |
| wr_addr | output | 8 | Address of the committed frame, valid with `wr_pulse` |
| wr_data | output | 8 | Data of the committed frame, valid with `wr_pulse` |

## Verification
On every cycle, the assertions check four things. A write notice is always a single cycle wide and always follows a detected host clock edge under an active strobe. The frame counter is empty after the strobe drops. The register file holds still unless a write is in progress, and when one is, the addressed register takes the written value. Whether bit order, address/data split, the discard of partial frames and back-to-back framing are right can only be shown by the bench's scenarios. It sweeps all 256 addresses in both modes and compares every register against values computed arithmetically.

// File: rtl/strbport_pkg.sv
package strbport_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  // Append one serial bit to the bits gathered so far (MSB first).
  function automatic logic [FRAME_W-1:0] ser_next(input logic [FRAME_W-2:0] sofar,
                                                  input logic bit_in);
    return {sofar, bit_in};
  endfunction

  // True when this edge is the last one of a frame.
  function automatic logic frame_last(input logic serial, input logic [CNT_W-1:0] cnt);
    if (serial) return cnt == CNT_W'(FRAME_W - 1);
    else        return cnt == CNT_W'(1);
  endfunction
endpackage

// File: rtl/strbport_sync.sv
module strbport_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/strbport_frame.sv
module strbport_frame
  import strbport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_s,
  input  logic              hclk_s,
  input  logic [DATA_W-1:0] hdat_s,
  input  logic              serial,
  output logic              pulse,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data
);
  logic               hclk_q;
  logic               rise;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-2:0] sh;
  logic [FRAME_W-1:0] full;
  logic               last;

  assign rise = hclk_s & ~hclk_q;
  assign full = ser_next(sh, hdat_s[0]);
  assign last = frame_last(serial, cnt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hclk_q <= 1'b0;
    else        hclk_q <= hclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sh     <= '0;
      pulse  <= 1'b0;
      c_addr <= '0;
      c_data <= '0;
    end else if (!strb_s) begin
      cnt   <= '0;
      sh    <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (rise) begin
        if (last) begin
          pulse <= 1'b1;
          cnt   <= '0;
          if (serial) begin
            c_addr <= full[FRAME_W-1:DATA_W];
            c_data <= full[DATA_W-1:0];
          end else begin
            c_addr <= sh[ADDR_W-1:0];
            c_data <= hdat_s;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (serial) sh <= full[FRAME_W-2:0];
          else        sh <= {{(FRAME_W-1-ADDR_W){1'b0}}, hdat_s};
        end
      end
    end
  end

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  assert_pulse_from_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> ($past(rise) && $past(strb_s)));
  assert_abort_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_s) |=> (cnt == '0));
endmodule

// File: rtl/strbport_regs.sv
module strbport_regs
  import strbport_pkg::*;
#(
  parameter int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0]       mem [DEPTH];
  logic [DEPTH*DATA_W-1:0] mem_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign mem_flat[g*DATA_W +: DATA_W] = mem[g];
    end
  endgenerate

  assign rdata = mem[raddr];

  assert_hold_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem_flat));
  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/strbport.sv
module strbport
  import strbport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_strobe,
  input  logic              host_clk,
  input  logic [7:0]        host_data,
  input  logic              mode_serial,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int SYNC_W = 2 + DATA_W;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] syn_out;
  logic              strb_s;
  logic              hclk_s;
  logic [DATA_W-1:0] hdat_s;

  assign raw_in = {host_strobe, host_clk, host_data};
  assign {strb_s, hclk_s, hdat_s} = syn_out;

  strbport_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_in), .d_sync(syn_out)
  );

  strbport_frame u_frame (
    .clk(clk), .rst_n(rst_n), .strb_s(strb_s), .hclk_s(hclk_s),
    .hdat_s(hdat_s), .serial(mode_serial),
    .pulse(wr_pulse), .c_addr(wr_addr), .c_data(wr_data)
  );

  strbport_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_pulse), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !wr_pulse);
endmodule

// File: tb/strbport_bench.sv
module strbport_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_strobe = 1'b0;
  logic       host_clk = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic       mode_serial = 1'b1;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       wr_pulse;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;

  int n_cmp = 0;
  int n_bad = 0;
  int n_pulse = 0;
  logic [7:0] last_a = 8'h00;
  logic [7:0] last_d = 8'h00;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strbport u_strbport (
    .clk(clk), .rst_n(rst_n), .host_strobe(host_strobe), .host_clk(host_clk),
    .host_data(host_data), .mode_serial(mode_serial), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) if (wr_pulse) begin
    n_pulse++;
    last_a = wr_addr;
    last_d = wr_data;
  end

  function automatic logic [7:0] pat_s(input int a);
    return 8'((a * 37 + 11) % 256);
  endfunction
  function automatic logic [7:0] pat_p(input int a);
    return ~8'((a * 13 + 5) % 256);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic hedge(input logic [7:0] d);
    host_data = d;
    waitc(HP);
    host_clk = 1'b1;
    waitc(HP / 2);
    host_data = ~d;              // change while clock high: must not matter (R4)
    waitc(HP - HP / 2);
    host_clk = 1'b0;
  endtask

  task automatic sel_on;
    host_strobe = 1'b1;
    waitc(HP);
  endtask

  task automatic sel_off;
    waitc(HP);
    host_strobe = 1'b0;
    waitc(2 * HP);
  endtask

  task automatic ser_body(input logic [7:0] a, input logic [7:0] d);
    logic [15:0] w;
    w = {a, d};
    for (int i = 15; i >= 0; i--) hedge({7'h00, w[i]});
  endtask

  task automatic par_body(input logic [7:0] a, input logic [7:0] d);
    hedge(a);
    hedge(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int p0;
    waitc(3);
    rst_n = 1'b1;
    waitc(2);
    // R1: reset state
    chk("R1 wr_pulse", wr_pulse, 0);
    for (int a = 0; a < 256; a++) rd_chk("R1", 8'(a), 8'h00);

    // R2: serial sweep over all addresses
    mode_serial = 1'b1;
    for (int a = 0; a < 256; a++) begin
      p0 = n_pulse;
      sel_on();
      ser_body(8'(a), pat_s(a));
      sel_off();
      chk("R7 pulse count", n_pulse - p0, 1);
      if (a % 32 == 5) begin
        chk("R7 wr_addr", last_a, a);
        chk("R7 wr_data", last_d, pat_s(a));
      end
    end
    for (int a = 0; a < 256; a++) rd_chk("R2/R9", 8'(a), pat_s(a));

    // R3: parallel sweep over all addresses
    mode_serial = 1'b0;
    waitc(2);
    for (int a = 0; a < 256; a++) begin
      p0 = n_pulse;
      sel_on();
      par_body(8'(a), pat_p(a));
      sel_off();
      chk("R7 pulse count par", n_pulse - p0, 1);
    end
    for (int a = 0; a < 256; a++) rd_chk("R3/R9", 8'(a), pat_p(a));

    // R6: aborted parallel frame (address byte only)
    p0 = n_pulse;
    sel_on();
    hedge(8'h40);
    sel_off();
    chk("R6 par no pulse", n_pulse - p0, 0);
    rd_chk("R6 par", 8'h40, pat_p(8'h40));

    // R5: clocks with strobe low, then a clean frame
    p0 = n_pulse;
    for (int i = 0; i < 5; i++) hedge(8'hA5);
    waitc(HP);
    chk("R5 no pulse", n_pulse - p0, 0);
    sel_on();
    par_body(8'h11, 8'h3C);
    sel_off();
    rd_chk("R5 frame aligned", 8'h11, 8'h3C);

    // R8: back-to-back parallel frames in one strobe window
    sel_on();
    par_body(8'h20, 8'h81);
    par_body(8'h21, 8'h82);
    sel_off();
    rd_chk("R8 par first", 8'h20, 8'h81);
    rd_chk("R8 par second", 8'h21, 8'h82);
    rd_chk("R9 par neighbour", 8'h22, pat_p(8'h22));

    // Serial corner cases
    mode_serial = 1'b1;
    waitc(2);
    // R6: serial abort after 10 bits
    p0 = n_pulse;
    sel_on();
    for (int i = 0; i < 10; i++) hedge({7'h00, 1'(i & 1)});
    sel_off();
    chk("R6 ser no pulse", n_pulse - p0, 0);
    rd_chk("R6 ser", 8'h55, pat_p(8'h55));
    rd_chk("R6 ser 0xAA", 8'hAA, pat_p(8'hAA));
    // R5: serial bits with strobe low leave no residue
    for (int i = 0; i < 7; i++) hedge(8'h01);
    sel_on();
    ser_body(8'h90, 8'hC3);
    sel_off();
    rd_chk("R5 ser aligned", 8'h90, 8'hC3);
    // R8: serial back-to-back
    sel_on();
    ser_body(8'hFE, 8'h01);
    ser_body(8'hFF, 8'h80);
    sel_off();
    rd_chk("R8 ser first", 8'hFE, 8'h01);
    rd_chk("R8 ser second", 8'hFF, 8'h80);
    rd_chk("R9 ser neighbour", 8'hFD, pat_p(8'hFD));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule